// File: doc/BRIEF.md
# RNG Seed-Error Recovery Sequencer

A bus-master state machine that fetches 32-bit random words from a random number generator's register block on behalf of a consumer, without processor help. It issues one read or write at a time on a simple 32-bit request/acknowledge bus. It examines the status word before each data read and delivers every good word on a ready/valid output. When the generator reports a seed error, it runs a recovery procedure on its own. It also treats an all-zero data word as a late seed error.

Two recovery procedures exist. The parameter `COND_RST` picks one at build time. When the generator has a conditional-reset control bit, recovery toggles that bit and then runs two polled waits. Without that bit, recovery clears the interrupt flag and flushes the generator's pipeline by reading and discarding a fixed number of words. Every poll is bounded by a cycle-count timeout. When recoveries keep failing, the block raises a sticky unrecoverable-error output.

A request starts with a one-cycle `start` pulse that carries a word count. The `block_mode` input chooses what happens when the status register reads all zero: the block either waits for the generator or gives up at once.

Top module: `rng_seed_recover`

## Requirements
- R1: A `start` pulse with a non-zero `nwords` in idle makes `busy` rise. The block then delivers `nwords` non-zero words in the order they were read, each held stable on `out_data` with `out_valid` until `out_ready`. `busy` falls after the last word is accepted.
- R2: At most one bus transaction is open at a time. `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until `bus_ack`. Control is at byte offset 0x00, status at 0x04 and data at 0x08.
- R3: A data word that reads as zero is never delivered. It starts a recovery, and the word count is not reduced.
- R4: Status bit map: bit 0 is data ready, bit 2 is seed error current, bit 5 is clock-error interrupt and bit 6 is seed-error interrupt. If status is neither 0x1 nor zero, bit 6 is clear and bit 5 is set, the block writes 0 to status and then reads data.
- R5: With `COND_RST`=1 and status bit 2 set, recovery runs these steps: read control; write it with bit 30 set; write it with bit 30 clear; poll control until bit 30 reads 0; read status and require bit 6 clear; poll status until bit 2 reads 0.
- R6: With `COND_RST`=1 and status bit 2 clear, recovery writes status once, with bit 6 cleared and the other bits as read, and writes nothing to control.
- R7: With `COND_RST`=0, recovery writes status with bit 6 cleared, reads and discards `FLUSH_WORDS` data words, then reads status and counts the recovery as failed if bit 6 is set. It never writes control.
- R8: If status reads all zero and `block_mode`=1, the block keeps polling status until it is non-zero. If `block_mode`=0, it ends the request at once and delivers nothing more.
- R9: A poll still unmet after `TIMEOUT` cycles sets the sticky `timeout_err` output. A timed-out status wait ends the request. A timed-out poll during recovery counts as a failed recovery, and the block then continues reading.
- R10: Each failed recovery increments a counter, which is cleared by a delivered word or by `start`. The failure that comes after `MAX_FAILS` earlier ones sets the sticky `fatal` output and returns the block to idle. After that, `start` is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (idle only) |
| nwords | input | CNT_W | Number of words to deliver |
| block_mode | input | 1 | 1: wait on empty status, 0: stop |
| busy | output | 1 | Request in progress |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction done (read data valid) |
| bus_rdata | input | 32 | Read data |
| out_valid | output | 1 | Random word available |
| out_data | output | 32 | Random word |
| out_ready | input | 1 | Consumer accepts word |
| timeout_err | output | 1 | Sticky poll-timeout flag |
| fatal | output | 1 | Sticky unrecoverable seed error |

## Verification
The bench targets these cases:
- A zero word placed between two good ones. A design that forwarded it, or counted it against the request, would deliver a wrong stream.
- The two conditional-reset branches. If the design took the wrong branch, the bench would see control writes where none belong or a missing bit-30 toggle. If it skipped the polls, it would deliver before the model released its busy bits.
- The flush path. The bench counts exactly twelve discarded reads plus one delivered read.
- Failure conditions that never heal. These must give `fatal` after exactly four recoveries, eight control writes or forty-eight flush reads. A bound off by one changes those counts.
- The empty-status cases. The bench checks a delayed wake-up, an immediate stop and a timeout, against a design that hangs or gives up too early.

// File: rtl/rng_seed_recover.sv
module rng_seed_recover #(
  parameter bit       COND_RST    = 1'b1,
  parameter int       TIMEOUT     = 1000,
  parameter int       MAX_FAILS   = 3,
  parameter int       FLUSH_WORDS = 12,
  parameter int       AW          = 8,
  parameter int       CNT_W       = 16,
  parameter logic [7:0] CTRL_OFS  = 8'h00,
  parameter logic [7:0] STAT_OFS  = 8'h04,
  parameter logic [7:0] DATA_OFS  = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] nwords,
  input  logic             block_mode,
  output logic             busy,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [31:0]      bus_wdata,
  input  logic             bus_ack,
  input  logic [31:0]      bus_rdata,
  output logic             out_valid,
  output logic [31:0]      out_data,
  input  logic             out_ready,
  output logic             timeout_err,
  output logic             fatal
);
  localparam int TW  = $clog2(TIMEOUT + 1);
  localparam int FW  = $clog2(FLUSH_WORDS + 1);
  localparam int FCW = $clog2(MAX_FAILS + 2);
  localparam logic [TW-1:0]  TMAX  = TW'(TIMEOUT);
  localparam logic [FW-1:0]  FLAST = FW'(FLUSH_WORDS - 1);
  localparam logic [FCW-1:0] FMAX  = FCW'(MAX_FAILS);
  localparam int B_SECS = 2, B_CEIS = 5, B_SEIS = 6, B_CRST = 30;

  typedef enum logic [3:0] {
    S_IDLE, S_RSR, S_WAIT, S_CLR, S_RDR, S_OUT, S_ASR, S_WSI,
    S_FL, S_VSR, S_RCR, S_WCS, S_WCC, S_PCR, S_CSR, S_PSR
  } st_t;

  st_t              st;
  logic [31:0]      sr_q, cr_q, word_q;
  logic [CNT_W-1:0] left;
  logic [FCW-1:0]   fails;
  logic [FW-1:0]    fl;
  logic [TW-1:0]    tmr;
  logic             to_q, fatal_q;
  logic             rec_ok, rec_bad, poll_to, tmo;

  function automatic st_t classify(input logic [31:0] s);
    if (s == 32'd1)      return S_RDR;
    else if (s[B_SEIS])  return S_ASR;
    else if (s[B_CEIS])  return S_CLR;
    else                 return S_RDR;
  endfunction

  assign tmo         = (tmr >= TMAX);
  assign busy        = (st != S_IDLE);
  assign out_valid   = (st == S_OUT);
  assign out_data    = word_q;
  assign timeout_err = to_q;
  assign fatal       = fatal_q;
  assign bus_req     = (st != S_IDLE) && (st != S_OUT);

  always_comb begin
    bus_we    = 1'b0;
    bus_addr  = AW'(STAT_OFS);
    bus_wdata = 32'd0;
    case (st)
      S_CLR: bus_we = 1'b1;
      S_RDR, S_FL: bus_addr = AW'(DATA_OFS);
      S_WSI: begin bus_we = 1'b1; bus_wdata = sr_q & ~(32'd1 << B_SEIS); end
      S_RCR, S_PCR: bus_addr = AW'(CTRL_OFS);
      S_WCS: begin bus_we = 1'b1; bus_addr = AW'(CTRL_OFS); bus_wdata = cr_q | (32'd1 << B_CRST); end
      S_WCC: begin bus_we = 1'b1; bus_addr = AW'(CTRL_OFS); bus_wdata = cr_q & ~(32'd1 << B_CRST); end
      default: ;
    endcase
  end

  always_comb begin
    rec_ok = 1'b0; rec_bad = 1'b0; poll_to = 1'b0;
    if (bus_ack) begin
      case (st)
        S_WSI: rec_ok = COND_RST;
        S_VSR: if (bus_rdata[B_SEIS]) rec_bad = 1'b1; else rec_ok = 1'b1;
        S_CSR: rec_bad = bus_rdata[B_SEIS];
        S_PCR: if (bus_rdata[B_CRST] && tmo) begin rec_bad = 1'b1; poll_to = 1'b1; end
        S_PSR: if (!bus_rdata[B_SECS]) rec_ok = 1'b1;
               else if (tmo) begin rec_bad = 1'b1; poll_to = 1'b1; end
        S_WAIT: poll_to = (bus_rdata == 32'd0) && tmo;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sr_q <= '0; cr_q <= '0; word_q <= '0; left <= '0;
      fails <= '0; fl <= '0; tmr <= '0; to_q <= 1'b0; fatal_q <= 1'b0;
    end else begin
      if (!tmo) tmr <= tmr + 1'b1;
      if (poll_to) to_q <= 1'b1;
      if (rec_ok) st <= S_RSR;
      if (rec_bad) begin
        if (fails >= FMAX) begin fatal_q <= 1'b1; st <= S_IDLE; end
        else begin fails <= fails + 1'b1; st <= S_RSR; end
      end
      case (st)
        S_IDLE: if (start && !fatal_q && nwords != '0) begin
                  left <= nwords; fails <= '0; st <= S_RSR;
                end
        S_RSR: if (bus_ack) begin
                 if (bus_rdata == 32'd0) begin
                   if (block_mode) begin st <= S_WAIT; tmr <= '0; end
                   else st <= S_IDLE;
                 end else st <= classify(bus_rdata);
               end
        S_WAIT: if (bus_ack) begin
                  if (bus_rdata != 32'd0) st <= classify(bus_rdata);
                  else if (tmo) st <= S_IDLE;
                end
        S_CLR: if (bus_ack) st <= S_RDR;
        S_RDR: if (bus_ack) begin
                 if (bus_rdata == 32'd0) st <= S_ASR;
                 else begin word_q <= bus_rdata; st <= S_OUT; end
               end
        S_OUT: if (out_ready) begin
                 fails <= '0;
                 left  <= left - 1'b1;
                 st    <= (left == CNT_W'(1)) ? S_IDLE : S_RSR;
               end
        S_ASR: if (bus_ack) begin
                 sr_q <= bus_rdata;
                 st   <= (COND_RST && bus_rdata[B_SECS]) ? S_RCR : S_WSI;
               end
        S_WSI: if (bus_ack && !COND_RST) begin fl <= '0; st <= S_FL; end
        S_FL:  if (bus_ack) begin
                 if (fl == FLAST) st <= S_VSR;
                 else fl <= fl + 1'b1;
               end
        S_RCR: if (bus_ack) begin cr_q <= bus_rdata; st <= S_WCS; end
        S_WCS: if (bus_ack) st <= S_WCC;
        S_WCC: if (bus_ack) begin st <= S_PCR; tmr <= '0; end
        S_PCR: if (bus_ack && !bus_rdata[B_CRST]) st <= S_CSR;
        S_CSR: if (bus_ack && !bus_rdata[B_SEIS]) begin st <= S_PSR; tmr <= '0; end
        default: ;
      endcase
    end
  end

  p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_no_zero_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data != 32'd0);
  p_no_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_addr == AW'(CTRL_OFS) |-> COND_RST);
  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  p_fatal_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal && !busy);
  p_fatal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal) |-> !bus_req && !out_valid);
endmodule

// File: tb/rng_seed_recover_tb_top.sv
module rng_regs_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata
);
  bit drdy = 1'b1, cecs, secs, ceis, seis, seis_sticky;
  int cr_hold = 1, secs_hold = 1, cr_busy = 0, secs_cnt = -1, filler = 0;
  int dr_reads = 0, cr_writes = 0, sr_writes = 0;
  logic [31:0] cr = 32'h0000_0104;
  logic [31:0] last_srw = 32'hFFFF_FFFF;
  logic [31:0] cr_w[$];
  logic [31:0] dq[$];

  always @(posedge clk) begin
    if (!rst_n) begin ack <= 1'b0; rdata <= '0; end
    else if (req && !ack) begin
      ack <= 1'b1;
      if (we) begin
        rdata <= '0;
        if (addr == 8'h00) begin
          cr_writes++; cr_w.push_back(wdata);
          if (cr[30] && !wdata[30]) begin
            cr_busy = cr_hold;
            if (!seis_sticky) begin seis = 1'b0; secs_cnt = secs_hold; end
          end
          cr = wdata;
        end else if (addr == 8'h04) begin
          sr_writes++; last_srw = wdata;
          if (!seis_sticky && !wdata[6]) seis = 1'b0;
          if (!wdata[5]) ceis = 1'b0;
        end
      end else if (addr == 8'h00) begin
        rdata <= {cr[31], cr_busy > 0, cr[29:0]};
        if (cr_busy > 0) cr_busy--;
      end else if (addr == 8'h04) begin
        rdata <= {25'd0, seis, ceis, 2'b00, secs, cecs, drdy};
        if (secs_cnt > 0) begin secs_cnt--; if (secs_cnt == 0) secs = 1'b0; end
      end else begin
        dr_reads++;
        if (dq.size() > 0) rdata <= dq.pop_front();
        else begin filler++; rdata <= 32'hF000_0000 + filler; end
      end
    end else ack <= 1'b0;
  end
endmodule

module rng_seed_recover_tb_top;
  localparam int TO = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        st_a = 0, st_b = 0, blk_a = 1, blk_b = 1;
  logic [15:0] nw_a = 0, nw_b = 0;
  wire         rdy = (cyc % 3) != 2;

  logic        busy_a, req_a, we_a, ack_a, ov_a, to_a, fat_a;
  logic [7:0]  ad_a;
  logic [31:0] wd_a, rd_a, od_a;
  logic        busy_b, req_b, we_b, ack_b, ov_b, to_b, fat_b;
  logic [7:0]  ad_b;
  logic [31:0] wd_b, rd_b, od_b;

  rng_seed_recover #(.COND_RST(1'b1), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(st_a), .nwords(nw_a), .block_mode(blk_a), .busy(busy_a),
    .bus_req(req_a), .bus_we(we_a), .bus_addr(ad_a), .bus_wdata(wd_a), .bus_ack(ack_a),
    .bus_rdata(rd_a), .out_valid(ov_a), .out_data(od_a), .out_ready(rdy),
    .timeout_err(to_a), .fatal(fat_a));
  rng_regs_model mdl_a (.clk(clk), .rst_n(rst_n), .req(req_a), .we(we_a), .addr(ad_a),
    .wdata(wd_a), .ack(ack_a), .rdata(rd_a));

  rng_seed_recover #(.COND_RST(1'b0), .TIMEOUT(TO)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .start(st_b), .nwords(nw_b), .block_mode(blk_b), .busy(busy_b),
    .bus_req(req_b), .bus_we(we_b), .bus_addr(ad_b), .bus_wdata(wd_b), .bus_ack(ack_b),
    .bus_rdata(rd_b), .out_valid(ov_b), .out_data(od_b), .out_ready(rdy),
    .timeout_err(to_b), .fatal(fat_b));
  rng_regs_model mdl_b (.clk(clk), .rst_n(rst_n), .req(req_b), .we(we_b), .addr(ad_b),
    .wdata(wd_b), .ack(ack_b), .rdata(rd_b));

  logic [31:0] exp_a[$], exp_b[$];

  task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && ov_a && rdy) begin
    if (exp_a.size() == 0) chk(0, "R1 unexpected word A", od_a, 0);
    else begin logic [31:0] e; e = exp_a.pop_front(); chk(od_a == e, "R1 word order A", od_a, e); end
  end
  always @(negedge clk) if (rst_n && ov_b && rdy) begin
    if (exp_b.size() == 0) chk(0, "R1 unexpected word B", od_b, 0);
    else begin logic [31:0] e; e = exp_b.pop_front(); chk(od_b == e, "R1 word order B", od_b, e); end
  end

  task automatic run_a(input int n, input bit blk);
    @(negedge clk); st_a = 1; nw_a = 16'(n); blk_a = blk;
    @(negedge clk); st_a = 0;
    for (int i = 0; i < 20000 && busy_a; i++) @(negedge clk);
  endtask
  task automatic run_b(input int n);
    @(negedge clk); st_b = 1; nw_b = 16'(n); blk_b = 1;
    @(negedge clk); st_b = 0;
    for (int i = 0; i < 20000 && busy_b; i++) @(negedge clk);
  endtask

  initial begin
    automatic int w0, w1, t0;
    repeat (4) @(negedge clk);
    chk(!busy_a && !ov_a && !req_a && !to_a && !fat_a, "R1 reset state", busy_a, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 plain stream
    mdl_a.dq = '{32'h11, 32'h22, 32'h33}; exp_a = '{32'h11, 32'h22, 32'h33};
    run_a(3, 1);
    chk(!busy_a && exp_a.size() == 0, "R1 three words delivered", exp_a.size(), 0);

    // R3 + R6 zero word, auto-reset path
    w0 = mdl_a.sr_writes; w1 = mdl_a.cr_writes;
    mdl_a.dq = '{32'h44, 32'h0, 32'h55}; exp_a = '{32'h44, 32'h55};
    run_a(2, 1);
    chk(exp_a.size() == 0, "R3 zero word skipped", exp_a.size(), 0);
    chk(mdl_a.sr_writes == w0 + 1 && mdl_a.last_srw == 32'h1, "R6 single status write", mdl_a.last_srw, 1);
    chk(mdl_a.cr_writes == w1, "R6 no control write", mdl_a.cr_writes, w1);

    // R4 clock-error interrupt
    mdl_a.ceis = 1; mdl_a.dq = '{32'h5A}; exp_a = '{32'h5A};
    run_a(1, 1);
    chk(mdl_a.last_srw == 0 && mdl_a.ceis == 0, "R4 status cleared", mdl_a.last_srw, 0);
    chk(exp_a.size() == 0, "R4 word after clear", exp_a.size(), 0);

    // R5 conditional-reset recovery
    w1 = mdl_a.cr_writes;
    mdl_a.seis = 1; mdl_a.secs = 1; mdl_a.cr_hold = 2; mdl_a.secs_hold = 2;
    mdl_a.dq = '{32'h66}; exp_a = '{32'h66};
    run_a(1, 1);
    chk(mdl_a.cr_writes == w1 + 2, "R5 two control writes", mdl_a.cr_writes, w1 + 2);
    chk(mdl_a.cr_w[w1][30] == 1 && mdl_a.cr_w[w1+1][30] == 0, "R5 bit30 toggle", mdl_a.cr_w[w1], 32'h4000_0104);
    chk(exp_a.size() == 0 && !to_a && !mdl_a.secs, "R5 word after polls", to_a, 0);

    // R8 blocking wait with late wake-up
    mdl_a.drdy = 0; mdl_a.dq = '{32'h77}; exp_a = '{32'h77};
    fork
      run_a(1, 1);
      begin repeat (15) @(negedge clk); mdl_a.drdy = 1; end
    join
    chk(exp_a.size() == 0 && !to_a, "R8 blocking wait delivers", to_a, 0);

    // R8 non-blocking empty status
    mdl_a.drdy = 0; w0 = mdl_a.dr_reads;
    run_a(2, 0);
    chk(!busy_a && mdl_a.dr_reads == w0, "R8 non-blocking stop", mdl_a.dr_reads, w0);

    // R9 recovery poll timeout counts as failure, reading continues
    mdl_a.drdy = 1; mdl_a.seis = 1; mdl_a.secs = 1; mdl_a.secs_hold = -1;
    mdl_a.dq = '{32'h1234}; exp_a = '{32'h1234};
    run_a(1, 1);
    chk(to_a == 1, "R9 recovery timeout flag", to_a, 1);
    chk(exp_a.size() == 0 && !fat_a, "R9 continues after timeout", fat_a, 0);
    mdl_a.secs = 0; mdl_a.secs_hold = 1;

    // R9 blocking wait timeout ends request
    mdl_a.drdy = 0; w0 = mdl_a.dr_reads; t0 = cyc;
    run_a(1, 1);
    chk(!busy_a && mdl_a.dr_reads == w0 && (cyc - t0) >= TO, "R9 wait timeout", cyc - t0, TO);
    mdl_a.drdy = 1;

    // R10 fatal after four failed conditional-reset recoveries
    w1 = mdl_a.cr_writes;
    mdl_a.seis = 1; mdl_a.secs = 1; mdl_a.seis_sticky = 1;
    run_a(1, 1);
    chk(fat_a == 1 && !busy_a, "R10 fatal raised", fat_a, 1);
    chk(mdl_a.cr_writes == w1 + 8, "R10 four recoveries", mdl_a.cr_writes - w1, 8);
    @(negedge clk); st_a = 1; nw_a = 1; @(negedge clk); st_a = 0;
    repeat (3) @(negedge clk);
    chk(!busy_a && !req_a, "R10 start ignored", busy_a, 0);

    // R7 flush path
    w0 = mdl_b.dr_reads; w1 = mdl_b.sr_writes;
    mdl_b.seis = 1; mdl_b.dq = '{};
    for (int k = 0; k < 12; k++) mdl_b.dq.push_back(32'hD0 + k);
    mdl_b.dq.push_back(32'h88); exp_b = '{32'h88};
    run_b(1);
    chk(mdl_b.dr_reads == w0 + 13, "R7 twelve discarded reads", mdl_b.dr_reads - w0, 13);
    chk(mdl_b.sr_writes == w1 + 1 && mdl_b.last_srw == 32'h1, "R7 status write", mdl_b.last_srw, 1);
    chk(exp_b.size() == 0 && mdl_b.cr_writes == 0, "R7 word after flush", mdl_b.cr_writes, 0);

    // R10 fatal on flush path
    w0 = mdl_b.dr_reads;
    mdl_b.seis = 1; mdl_b.seis_sticky = 1;
    run_b(1);
    chk(fat_b == 1 && mdl_b.dr_reads == w0 + 48, "R10 flush fatal", mdl_b.dr_reads - w0, 48);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule